// File: doc/BRIEF.md
# Video blanking and sync strobe generator

This block drives the horizontal sync strobe and the blanking strobe of an interlaced video decoder. An upstream timing source supplies a horizontal count that restarts at zero on every line, a frame line number, a field parity flag, a field-start pulse and a select between 525-line and 625-line operation. The block turns these inputs into two registered strobes whose trailing edges are set by two 8-bit programmable values.

The sync strobe starts at horizontal count zero. It ends at twice the programmed sync value, so the 8-bit value reaches counts up to 510. The blanking strobe starts on the field-start pulse. It ends at the start of a line that depends on the programmed blank value, the field parity and the line standard. Software writes the two values through a small address/data strobe port. A written value is held pending and applied only at the next line start, so no strobe is ever cut short or stretched in the middle of a line.

Top module: `vid_strobe_gen`

## Requirements
- R1: `hsync_o` rises in the cycle after `hcount_i` is 0, provided the effective sync end value is non-zero.
- R2: `hsync_o` falls in the cycle after `hcount_i` equals twice the effective sync end value, for every value from 1 to 255, which gives negate counts from 2 up to 510.
- R3: When the effective sync end value is 0, `hsync_o` stays low for the whole line.
- R4: With `std_625_i` = 0, `blank_o` falls in the cycle after a cycle with `hcount_i` = 0 and a `line_i` of n+5 in an odd field (`field_odd_i` = 1) or n+268 in an even field, where n is the blank end value.
- R5: With `std_625_i` = 1, the odd-field negate line is n+5 and the even-field negate line is n+318.
- R6: `field_start_i` = 1 makes `blank_o` high in the next cycle. This takes priority over a negate in the same cycle.
- R7: A write with `wr_en_i` = 1 sets the sync end value at address 0 and the blank end value at address 1. The new value takes effect from the next cycle with `hcount_i` = 0, and a write during a line leaves that line's strobes unchanged.
- R8: While `rst_ni` is low, both outputs are low. After reset the sync end value is 30h (negate at count 96) and the blank end value is 12h.
- R9: Writes to addresses 2 and 3 are ignored and change neither programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 sync end, 1 blank end) |
| wr_data_i | input | 8 | Register write data |
| hcount_i | input | 10 | Horizontal count, 0 at line start |
| line_i | input | 10 | Frame line number |
| field_odd_i | input | 1 | 1 in odd field |
| std_625_i | input | 1 | 1 selects 625-line, 0 selects 525-line |
| field_start_i | input | 1 | Start of field vertical interval |
| hsync_o | output | 1 | Horizontal sync strobe, active high |
| blank_o | output | 1 | Blanking strobe, active high |

## Verification
The assertions check on every cycle that each sync edge lines up with count zero or with twice the effective end value, that a zero end value suppresses the pulse, that a blank rise follows a field start, that a blank fall lands at line start on the computed line, and that ignored addresses and mid-line writes leave the programmed values alone. Only the bench scenarios can show the complete pulse shapes. These are the reset values, the 510-count extreme, the line offsets for both parities and both standards, and a write in mid-line that is deferred by exactly one line.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned NREG       = 2;
  localparam logic [7:0]  HEND_RST   = 8'h30;
  localparam logic [7:0]  VEND_RST   = 8'h12;
  localparam int unsigned ODD_OFS    = 5;
  localparam int unsigned EVEN_OFS_525 = 268;
  localparam int unsigned EVEN_OFS_625 = 318;
  typedef enum logic [1:0] {
    ADDR_HEND = 2'd0,
    ADDR_VEND = 2'd1
  } reg_addr_e;
endpackage

// File: rtl/vsg_regs.sv
module vsg_regs import vsg_pkg::*; #(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              line_start_i,
  output logic [REG_W-1:0]  hend_o,
  output logic [REG_W-1:0]  vend_o
);
  localparam logic [REG_W-1:0] RST_VAL [NREG] = '{HEND_RST, VEND_RST};

  logic [REG_W-1:0] pend_q [NREG];
  logic [REG_W-1:0] act_q  [NREG];
  logic [REG_W-1:0] eff    [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= RST_VAL[i];
        act_q[i]  <= RST_VAL[i];
      end else begin
        if (wr_en_i && wr_addr_i == ADDR_W'(i)) pend_q[i] <= wr_data_i;
        if (line_start_i) act_q[i] <= pend_q[i];
      end
    end
    // line start sees the pending value so the new line uses it at once
    assign eff[i] = line_start_i ? pend_q[i] : act_q[i];
  end

  assign hend_o = eff[ADDR_HEND];
  assign vend_o = eff[ADDR_VEND];

  a_r9_ignore_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= ADDR_W'(NREG)) |=>
      ($stable(pend_q[0]) && $stable(pend_q[1])));

  a_r7_hold_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> (line_start_i || ($stable(act_q[0]) && $stable(act_q[1]))));
endmodule

// File: rtl/vsg_hsync.sv
module vsg_hsync import vsg_pkg::*; #(
  parameter int unsigned HCNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HCNT_W-1:0] hcount_i,
  input  logic [REG_W-1:0]  hend_i,
  output logic              hsync_o
);
  logic [HCNT_W-1:0] neg_cnt;
  logic              hs_q;

  assign neg_cnt = HCNT_W'({hend_i, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hs_q <= 1'b0;
    else if (hcount_i == '0)    hs_q <= (hend_i != '0);
    else if (hcount_i == neg_cnt) hs_q <= 1'b0;
  end

  assign hsync_o = hs_q;

  a_r1_rise_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |-> ($past(hcount_i) == '0));

  a_r2_fall_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_o) |-> ($past(hcount_i) == HCNT_W'(2 * int'($past(hend_i)))));

  a_r3_zero_end_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcount_i == '0 && hend_i == '0) |=> !hsync_o);
endmodule

// File: rtl/vsg_blank.sv
module vsg_blank import vsg_pkg::*; #(
  parameter int unsigned HCNT_W = 10,
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HCNT_W-1:0] hcount_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_odd_i,
  input  logic              std_625_i,
  input  logic              field_start_i,
  input  logic [REG_W-1:0]  vend_i,
  output logic              blank_o
);
  logic [LINE_W-1:0] tgt;
  logic              bl_q;

  always_comb begin
    if (field_odd_i)    tgt = LINE_W'(int'(vend_i) + ODD_OFS);
    else if (std_625_i) tgt = LINE_W'(int'(vend_i) + EVEN_OFS_625);
    else                tgt = LINE_W'(int'(vend_i) + EVEN_OFS_525);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               bl_q <= 1'b0;
    else if (field_start_i)                    bl_q <= 1'b1;
    else if (hcount_i == '0 && line_i == tgt)  bl_q <= 1'b0;
  end

  assign blank_o = bl_q;

  a_r6_rise_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i |=> blank_o);

  a_r4_fall_at_line_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blank_o) |-> ($past(hcount_i) == '0 && !$past(field_start_i)));

  a_r5_fall_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blank_o) |-> (int'($past(line_i)) == int'($past(vend_i)) +
      ($past(field_odd_i) ? 5 : ($past(std_625_i) ? 318 : 268))));
endmodule

// File: rtl/vid_strobe_gen.sv
module vid_strobe_gen import vsg_pkg::*; #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned HCNT_W = 10,
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [HCNT_W-1:0] hcount_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_odd_i,
  input  logic              std_625_i,
  input  logic              field_start_i,
  output logic              hsync_o,
  output logic              blank_o
);
  logic             line_start;
  logic [REG_W-1:0] hend, vend;

  assign line_start = (hcount_i == '0);

  vsg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .line_start_i(line_start), .hend_o(hend), .vend_o(vend)
  );

  vsg_hsync #(.HCNT_W(HCNT_W)) u_hsync (
    .clk_i, .rst_ni, .hcount_i, .hend_i(hend), .hsync_o
  );

  vsg_blank #(.HCNT_W(HCNT_W), .LINE_W(LINE_W)) u_blank (
    .clk_i, .rst_ni, .hcount_i, .line_i, .field_odd_i, .std_625_i,
    .field_start_i, .vend_i(vend), .blank_o
  );

  a_r8_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> (!hsync_o && !blank_o));
endmodule

// File: tb/sim_vid_strobe_gen.sv
module sim_vid_strobe_gen;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [9:0] hcount = 10'd1, line = 0;
  logic       odd = 1, s625 = 0, fs = 0;
  logic       hsync, blank;

  always #5 clk = ~clk;

  vid_strobe_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hcount_i(hcount), .line_i(line),
    .field_odd_i(odd), .std_625_i(s625), .field_start_i(fs),
    .hsync_o(hsync), .blank_o(blank)
  );

  int    total = 0, fails = 0;
  bit    done = 0;
  string tag = "R8";
  bit [1:0] exp_q[$];
  string    tag_q[$];

  // behavioural model from the requirements
  bit       hs_m = 0, bl_m = 0;
  bit [7:0] pend_h = 8'h30, pend_v = 8'h12, act_h = 8'h30, act_v = 8'h12;

  function automatic int neg_line(bit [7:0] n, bit o, bit p);
    if (o) return int'(n) + 5;
    return p ? int'(n) + 318 : int'(n) + 268;
  endfunction

  task automatic check(string t, bit [1:0] act, bit [1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {hsync,blank} actual %b expected %b", t, act, exp);
    end
  endtask

  task automatic step(int hc, int ln, bit f, bit we, bit [1:0] wa, bit [7:0] wd);
    bit [7:0] eh, ev;
    @(negedge clk);
    hcount = 10'(hc); line = 10'(ln); fs = f;
    wr_en = we; wr_addr = wa; wr_data = wd;
    eh = (hc == 0) ? pend_h : act_h;
    ev = (hc == 0) ? pend_v : act_v;
    if (hc == 0) begin act_h = pend_h; act_v = pend_v; end
    if (hc == 0) hs_m = (eh != 0);
    else if (hc == 2 * int'(eh)) hs_m = 0;
    if (f) bl_m = 1;
    else if (hc == 0 && ln == neg_line(ev, odd, s625)) bl_m = 0;
    if (we && wa == 2'd0) pend_h = wd;
    if (we && wa == 2'd1) pend_v = wd;
    exp_q.push_back({hs_m, bl_m});
    tag_q.push_back(tag);
  endtask

  task automatic run_line(int ln, int len, bit f, int wr_at, bit [1:0] wa, bit [7:0] wd);
    for (int c = 0; c < len; c++)
      step(c, ln, f && c == 0, c == wr_at, wa, wd);
  endtask

  // monitor
  initial forever begin
    @(posedge clk); #1;
    if (rst_n && exp_q.size() > 0) check(tag_q.pop_front(), {hsync, blank}, exp_q.pop_front());
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", {hsync, blank}, 2'b00);
    @(negedge clk) rst_n = 1;
    // R8/R1/R2: default sync end 30h -> negate at 96
    tag = "R8_R1_R2 default sync";
    run_line(1, 200, 0, -1, 0, 0);
    run_line(2, 200, 0, -1, 0, 0);
    // R7: mid-line write deferred to next line
    tag = "R7 deferred write";
    run_line(3, 200, 0, 50, 2'd0, 8'h10);
    run_line(4, 200, 0, -1, 0, 0);
    // R9: ignored addresses
    tag = "R9 ignored address";
    run_line(5, 200, 0, 10, 2'd2, 8'h00);
    run_line(6, 200, 0, 10, 2'd3, 8'h00);
    run_line(7, 200, 0, -1, 0, 0);
    // R2 extremes: 510 and 2
    tag = "R2 end FFh";
    run_line(8, 10, 0, 3, 2'd0, 8'hFF);
    run_line(9, 520, 0, -1, 0, 0);
    tag = "R2 end 01h";
    run_line(10, 10, 0, 3, 2'd0, 8'h01);
    run_line(11, 10, 0, -1, 0, 0);
    // R3: zero end value
    tag = "R3 zero end";
    run_line(12, 10, 0, 3, 2'd0, 8'h00);
    run_line(13, 120, 0, -1, 0, 0);
    // R6/R4: odd field 525, default n=12h -> line 23
    tag = "R6_R4 odd 525";
    odd = 1; s625 = 0;
    run_line(1, 8, 1, -1, 0, 0);
    run_line(22, 8, 0, -1, 0, 0);
    run_line(23, 8, 0, -1, 0, 0);
    run_line(24, 8, 0, -1, 0, 0);
    tag = "R4 even 525";
    odd = 0;
    run_line(264, 8, 1, -1, 0, 0);
    run_line(285, 8, 0, -1, 0, 0);
    run_line(286, 8, 0, -1, 0, 0);
    tag = "R5 even 625";
    s625 = 1;
    run_line(313, 8, 1, -1, 0, 0);
    run_line(286, 8, 0, -1, 0, 0);
    run_line(335, 8, 0, -1, 0, 0);
    run_line(336, 8, 0, -1, 0, 0);
    tag = "R5 odd 625";
    odd = 1;
    run_line(1, 8, 1, -1, 0, 0);
    run_line(23, 8, 0, -1, 0, 0);
    // R6 priority: start on the negate line
    tag = "R6 priority";
    run_line(23, 8, 1, -1, 0, 0);
    run_line(24, 8, 0, -1, 0, 0);
    // R7: blank end write, n=0 -> line 5
    tag = "R7 blank end write";
    s625 = 0;
    run_line(1, 8, 1, 4, 2'd1, 8'h00);
    run_line(23, 8, 0, -1, 0, 0);
    run_line(5, 8, 0, -1, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule